// File: doc/BRIEF.md
# Centre-Spread Frequency Sweep Controller

This block drives the fractional feedback divider of a spread-spectrum clock synthesizer. On every reference clock cycle it presents a signed offset word, a fraction of the nominal frequency. The word traces a triangular profile centred on zero. The synthesized clock therefore spreads equally above and below its nominal rate. The profile repeats every 2332 reference cycles whatever spread is chosen, so the modulation rate is the reference frequency divided by 2332.

The sweep depth comes from a lookup of nine settings. Two select inputs choose the setting. Each select carries a low, middle or high level that an analog sensor outside this block has already resolved into a 2-bit code. A sub-band index gives the input frequency slice, because a given setting spreads less as the reference frequency rises. An enable input switches spreading on and off. At board level the enable is pulled active and each select is pulled to its middle level, so those are the defaults when the pins are left open.

The control is a four-state machine:
- SW_OFF holds the offset at zero.
- SW_UP runs from zero up to the positive peak.
- SW_DOWN runs from the positive peak down to the negative peak.
- SW_BACK returns from the negative peak to zero.

The transitions are:
- OFF→UP on enable.
- UP→DOWN after a quarter period.
- DOWN→BACK after three quarters.
- BACK→UP at the period wrap, which is a boundary.
- Any state→OFF when the enable is low.

Top module: `ssc_spread_ctrl`

## Requirements
- R1: `bound_strobe` is high for exactly one cycle at the start of each modulation period. While the enable stays high, consecutive strobes are exactly 2332 cycles apart.
- R2: With phase p (0 at the strobe cycle) and latched peak P, the offset is trunc(P*t/583), rounded toward zero. The value t is p for p≤583, 1166−p for 583≤p≤1749, and p−2332 for p≥1749. The offset is +P at p=583, −P at p=1749, and 0 at p=0.
- R3: Select codes are 00 = low, 01 = middle, 10 = high, and 11 is treated as middle. The setting number is 3·row + col, with low=0, mid=1, high=2.
- R4: When `spread_en` is low at a clock edge, the offset and strobe are zero after that edge. When the enable is first seen high again, the next cycle is a boundary with zero offset, and the offset then rises.
- R5: The peak is P = floor(S·16777/1024), where S is the total spread in tenths of a percent. Examples: setting 4 (mid/mid) at sub-band 0 gives S=43 and P=704. Setting 8 (high/high) at sub-band 4 gives S=16 and P=262.
- R6: A change of the selects or sub-band takes effect only at the next boundary. The peak in use never changes mid-period.
- R7: A synchronous active-high `rst` clears the sweep, so the offset and strobe are 0 while it is held.
- R8: Sub-bands 0–3 cover the lower input range and 4–12 the upper range. Settings 2, 5, 7 and 8 are upper-range settings; the others are lower-range settings. A lower-range setting given sub-band >3 uses sub-band 3. An upper-range setting given sub-band <4 uses sub-band 4. A sub-band above 12 is treated as 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| spread_en | input | 1 | Spreading enable |
| sel_row | input | 2 | First three-level select code |
| sel_col | input | 2 | Second three-level select code |
| band | input | 4 | Input frequency sub-band index |
| offset | output | 16 | Signed frequency offset word |
| bound_strobe | output | 1 | One-cycle pulse at each period boundary |

## Verification
Some behaviours are checked by the assertions on every cycle:
- The strobe is a single cycle, and strobes are 2332 cycles apart, using a checker counter.
- The offset is zero at boundaries and while disabled.
- A re-enable restarts with a strobe.
- The magnitude never exceeds the latched peak.
- The peak only moves at a boundary.

The remaining behaviours can only be shown by the bench's scenarios:
- The exact triangular values.
- The lookup table entries and their clamping across sub-bands.
- The reading of code 11 as middle.
- The delayed effect of a mid-period select change.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    typedef enum logic [1:0] {LVL_LO, LVL_MID, LVL_HI} lvl_e;

    typedef enum logic [1:0] {SW_OFF, SW_UP, SW_DOWN, SW_BACK} sweep_e;

    function automatic lvl_e lvl_of(input logic [1:0] code);
        unique case (code)
            2'b00:   return LVL_LO;
            2'b10:   return LVL_HI;
            default: return LVL_MID;
        endcase
    endfunction

endpackage

// File: rtl/ssc_sel_decode.sv
module ssc_sel_decode
    import ssc_pkg::*;
#(
    parameter int BAND_W  = 4,
    parameter int SPR_W   = 6,
    parameter int PEAK_W  = 11,
    parameter int GAIN    = 16777,
    parameter int GAIN_SH = 10
) (
    input  logic [1:0]        sel_row,
    input  logic [1:0]        sel_col,
    input  logic [BAND_W-1:0] band,
    output logic [PEAK_W-1:0] peak
);
    localparam int LO_N = 4;
    localparam int HI_N = 9;

    // packed columns, entry 0 in the low bits
    localparam logic [SPR_W*LO_N-1:0] T0 = {SPR_W'(22), SPR_W'(25), SPR_W'(26), SPR_W'(29)};
    localparam logic [SPR_W*LO_N-1:0] T1 = {SPR_W'(21), SPR_W'(24), SPR_W'(25), SPR_W'(27)};
    localparam logic [SPR_W*LO_N-1:0] T3 = {SPR_W'(31), SPR_W'(34), SPR_W'(36), SPR_W'(39)};
    localparam logic [SPR_W*LO_N-1:0] T4 = {SPR_W'(35), SPR_W'(38), SPR_W'(40), SPR_W'(43)};
    localparam logic [SPR_W*LO_N-1:0] T6 = {SPR_W'(27), SPR_W'(29), SPR_W'(31), SPR_W'(33)};
    localparam logic [SPR_W*HI_N-1:0] T2 = {SPR_W'(16), SPR_W'(17), SPR_W'(18), SPR_W'(18),
        SPR_W'(18), SPR_W'(20), SPR_W'(20), SPR_W'(21), SPR_W'(24)};
    localparam logic [SPR_W*HI_N-1:0] T5 = {SPR_W'(9), SPR_W'(9), SPR_W'(10), SPR_W'(10),
        SPR_W'(10), SPR_W'(11), SPR_W'(11), SPR_W'(11), SPR_W'(13)};
    localparam logic [SPR_W*HI_N-1:0] T7 = {SPR_W'(23), SPR_W'(23), SPR_W'(24), SPR_W'(24),
        SPR_W'(25), SPR_W'(26), SPR_W'(26), SPR_W'(27), SPR_W'(30)};
    localparam logic [SPR_W*HI_N-1:0] T8 = {SPR_W'(11), SPR_W'(11), SPR_W'(12), SPR_W'(12),
        SPR_W'(12), SPR_W'(13), SPR_W'(13), SPR_W'(14), SPR_W'(16)};

    int                setting;
    int                b;
    int                lo_ix;
    int                hi_ix;
    int                prod;
    logic [SPR_W-1:0]  spr;

    always_comb begin
        setting = 3 * int'(lvl_of(sel_row)) + int'(lvl_of(sel_col));
        b       = int'(band);
        lo_ix   = (b > LO_N - 1) ? LO_N - 1 : b;
        hi_ix   = (b < LO_N) ? 0 : ((b > LO_N + HI_N - 1) ? HI_N - 1 : b - LO_N);
        unique case (setting)
            0:       spr = T0[lo_ix*SPR_W +: SPR_W];
            1:       spr = T1[lo_ix*SPR_W +: SPR_W];
            2:       spr = T2[hi_ix*SPR_W +: SPR_W];
            3:       spr = T3[lo_ix*SPR_W +: SPR_W];
            4:       spr = T4[lo_ix*SPR_W +: SPR_W];
            5:       spr = T5[hi_ix*SPR_W +: SPR_W];
            6:       spr = T6[lo_ix*SPR_W +: SPR_W];
            7:       spr = T7[hi_ix*SPR_W +: SPR_W];
            8:       spr = T8[hi_ix*SPR_W +: SPR_W];
            default: spr = '0;
        endcase
        prod = int'(spr) * GAIN;
        peak = PEAK_W'(prod >>> GAIN_SH);
    end
endmodule

// File: rtl/ssc_phase_fsm.sv
module ssc_phase_fsm
    import ssc_pkg::*;
#(
    parameter int PERIOD = 2332,
    parameter int PEAK_W = 11,
    localparam int PH_W  = $clog2(PERIOD)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [PEAK_W-1:0] peak_in,
    output sweep_e            state,
    output logic [PH_W-1:0]   phase,
    output logic [PEAK_W-1:0] peak_q,
    output logic              strobe
);
    localparam int Q = PERIOD / 4;

    sweep_e            nxt;
    logic [PH_W-1:0]   ph_nxt;
    logic [PEAK_W-1:0] pk_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SW_OFF;
            phase  <= '0;
            peak_q <= '0;
        end else begin
            state  <= nxt;
            phase  <= ph_nxt;
            peak_q <= pk_nxt;
        end
    end

    always_comb begin
        nxt    = state;
        ph_nxt = phase + 1'b1;
        pk_nxt = peak_q;
        if (!en) begin
            nxt    = SW_OFF;
            ph_nxt = '0;
        end else begin
            unique case (state)
                SW_OFF: begin
                    nxt    = SW_UP;
                    ph_nxt = '0;
                    pk_nxt = peak_in;
                end
                SW_UP:   if (phase == PH_W'(Q - 1))     nxt = SW_DOWN;
                SW_DOWN: if (phase == PH_W'(3 * Q - 1)) nxt = SW_BACK;
                SW_BACK: if (phase == PH_W'(PERIOD - 1)) begin
                    nxt    = SW_UP;
                    ph_nxt = '0;
                    pk_nxt = peak_in;
                end
            endcase
        end
    end

    always_comb strobe = (state == SW_UP) && (phase == '0);
endmodule

// File: rtl/ssc_tri_shape.sv
module ssc_tri_shape
    import ssc_pkg::*;
#(
    parameter int PERIOD = 2332,
    parameter int PEAK_W = 11,
    parameter int OFS_W  = 16,
    localparam int PH_W  = $clog2(PERIOD)
) (
    input  sweep_e                   state,
    input  logic [PH_W-1:0]          phase,
    input  logic [PEAK_W-1:0]        peak,
    output logic signed [OFS_W-1:0]  offset
);
    localparam int Q = PERIOD / 4;

    int t;
    int prod;

    always_comb begin
        unique case (state)
            SW_OFF:  t = 0;
            SW_UP:   t = int'(phase);
            SW_DOWN: t = 2 * Q - int'(phase);
            SW_BACK: t = int'(phase) - PERIOD;
        endcase
        prod   = int'(peak) * t;
        offset = OFS_W'(prod / Q);
    end
endmodule

// File: rtl/ssc_spread_ctrl.sv
module ssc_spread_ctrl
    import ssc_pkg::*;
#(
    parameter int PERIOD = 2332,
    parameter int OFS_W  = 16,
    parameter int BAND_W = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     spread_en,
    input  logic [1:0]               sel_row,
    input  logic [1:0]               sel_col,
    input  logic [BAND_W-1:0]        band,
    output logic signed [OFS_W-1:0]  offset,
    output logic                     bound_strobe
);
    localparam int PEAK_W = 11;
    localparam int PH_W   = $clog2(PERIOD);

    logic [PEAK_W-1:0] peak_sel;
    logic [PEAK_W-1:0] peak_lat;
    logic [PH_W-1:0]   phase;
    sweep_e            state;

    ssc_sel_decode #(.BAND_W(BAND_W), .PEAK_W(PEAK_W)) u_dec (
        .sel_row (sel_row),
        .sel_col (sel_col),
        .band    (band),
        .peak    (peak_sel)
    );

    ssc_phase_fsm #(.PERIOD(PERIOD), .PEAK_W(PEAK_W)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .en      (spread_en),
        .peak_in (peak_sel),
        .state   (state),
        .phase   (phase),
        .peak_q  (peak_lat),
        .strobe  (bound_strobe)
    );

    ssc_tri_shape #(.PERIOD(PERIOD), .PEAK_W(PEAK_W), .OFS_W(OFS_W)) u_shape (
        .state  (state),
        .phase  (phase),
        .peak   (peak_lat),
        .offset (offset)
    );
endmodule

// File: rtl/ssc_spread_chk.sv
module ssc_spread_chk #(
    parameter int PERIOD = 2332,
    parameter int PEAK_W = 11,
    parameter int OFS_W  = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    spread_en,
    input logic signed [OFS_W-1:0] offset,
    input logic                    bound_strobe,
    input logic [PEAK_W-1:0]       peak_q
);
    int   gap;
    logic seen;

    always_ff @(posedge clk) begin
        if (rst || !spread_en) begin
            gap  <= 0;
            seen <= 1'b0;
        end else if (bound_strobe) begin
            gap  <= 1;
            seen <= 1'b1;
        end else begin
            gap  <= gap + 1;
        end
    end

    a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
        bound_strobe |=> !bound_strobe);

    a_r1_period: assert property (@(posedge clk) disable iff (rst)
        (bound_strobe && seen && spread_en) |-> (gap == PERIOD));

    a_r2_zero_at_bound: assert property (@(posedge clk) disable iff (rst)
        bound_strobe |-> (offset == '0));

    a_r2_within_peak: assert property (@(posedge clk) disable iff (rst)
        (int'(offset) <= int'(peak_q)) && (int'(offset) >= -int'(peak_q)));

    a_r4_off_zero: assert property (@(posedge clk) disable iff (rst)
        !spread_en |=> (offset == '0 && !bound_strobe));

    a_r4_restart: assert property (@(posedge clk) disable iff (rst)
        (spread_en && !$past(spread_en)) |=> bound_strobe);

    a_r6_latch_at_bound: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(peak_q)) |-> bound_strobe);
endmodule

bind ssc_spread_ctrl ssc_spread_chk #(.PERIOD(PERIOD), .PEAK_W(PEAK_W), .OFS_W(OFS_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .spread_en    (spread_en),
    .offset       (offset),
    .bound_strobe (bound_strobe),
    .peak_q       (peak_lat)
);

// File: tb/ssc_spread_ctrl_tb.sv
module ssc_spread_ctrl_tb;
    localparam int P  = 2332;
    localparam int QT = P / 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              en  = 1'b1;
    logic [1:0]        srow = 2'b01;
    logic [1:0]        scol = 2'b01;
    logic [3:0]        band = 4'd0;
    logic signed [15:0] offset;
    logic              strobe;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    string tag = "R2";

    // model state
    bit m_on = 0;
    int m_p  = 0;
    int m_pk = 0;
    int last_sb = -1;
    int cyc = 0;

    always #10 clk = ~clk;

    ssc_spread_ctrl u_dut (
        .clk (clk), .rst (rst), .spread_en (en), .sel_row (srow), .sel_col (scol),
        .band (band), .offset (offset), .bound_strobe (strobe)
    );

    function automatic int lvl(input logic [1:0] c);
        return (c == 2'b00) ? 0 : (c == 2'b10) ? 2 : 1;
    endfunction

    // spread in tenths of a percent per setting and sub-band (R5, R8)
    function automatic int spread_of(input int k, input int b);
        int lo [5][4] = '{'{29,26,25,22}, '{27,25,24,21}, '{39,36,34,31},
                          '{43,40,38,35}, '{33,31,29,27}};
        int hi [4][9] = '{'{24,21,20,20,18,18,18,17,16}, '{13,11,11,11,10,10,10,9,9},
                          '{30,27,26,26,25,24,24,23,23}, '{16,14,13,13,12,12,12,11,11}};
        int li = (b > 3) ? 3 : b;
        int hx = (b < 4) ? 0 : ((b > 12) ? 8 : b - 4);
        case (k)
            0: return lo[0][li];
            1: return lo[1][li];
            3: return lo[2][li];
            4: return lo[3][li];
            6: return lo[4][li];
            2: return hi[0][hx];
            5: return hi[1][hx];
            7: return hi[2][hx];
            default: return hi[3][hx];
        endcase
    endfunction

    function automatic int exp_peak(input logic [1:0] r, input logic [1:0] c, input logic [3:0] b);
        return (spread_of(3 * lvl(r) + lvl(c), int'(b)) * 16777) / 1024;
    endfunction

    function automatic int exp_off();
        int t;
        if (!m_on) return 0;
        if (m_p <= QT) t = m_p;
        else if (m_p <= 3 * QT) t = 2 * QT - m_p;
        else t = m_p - P;
        return (m_pk * t) / QT;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_on = 0; m_p = 0; m_pk = 0;
        end else if (!en) begin
            m_on = 0; m_p = 0;
        end else if (!m_on || m_p == P - 1) begin
            m_on = 1; m_p = 0; m_pk = exp_peak(srow, scol, band);
        end else begin
            m_p++;
        end
    end

    task automatic chk(input string rq, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", rq, act, exp, cyc);
        end
    endtask

    task automatic step();
        @(negedge clk);
        chk(tag, int'(offset), exp_off());
        chk("R1 strobe", int'(strobe), int'(m_on && m_p == 0));
        if (!en || rst) last_sb = -1;
        if (strobe) begin
            if (last_sb >= 0) chk("R1 spacing", cyc - last_sb, P);
            last_sb = cyc;
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic to_phase(input int ph);
        do step(); while (!(m_on && m_p == ph));
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        process::self().srandom(32'd7);
        // R7: held in reset
        tag = "R7";
        run(3);
        chk("R7 reset offset", int'(offset), 0);
        chk("R7 reset strobe", int'(strobe), 0);
        @(negedge clk) rst = 1'b0;
        // R5, R2: mid/mid at sub-band 0
        tag = "R2";
        to_phase(QT);
        chk("R5 peak mid/mid b0", int'(offset), 704);
        to_phase(3 * QT);
        chk("R2 trough", int'(offset), -704);
        to_phase(0);
        chk("R2 zero at boundary", int'(offset), 0);
        // R6: change mid-period, old peak stays until boundary
        tag = "R6";
        to_phase(100);
        srow = 2'b10; scol = 2'b10; band = 4'd4;
        to_phase(QT);
        chk("R6 old peak kept", int'(offset), 704);
        to_phase(QT);
        chk("R5 peak high/high b4", int'(offset), 262);
        // R3: code 11 as middle
        tag = "R3";
        srow = 2'b11; scol = 2'b11; band = 4'd0;
        to_phase(0);
        to_phase(QT);
        chk("R3 code 11 is middle", int'(offset), 704);
        // R4: disable then re-enable
        tag = "R4";
        @(negedge clk) en = 1'b0;
        run(5);
        chk("R4 disabled offset", int'(offset), 0);
        en = 1'b1;
        step();
        chk("R4 restart strobe", int'(strobe), 1);
        step();
        chk("R4 rising after restart", int'(offset > 0), 1);
        // R8: clamping across sub-bands
        tag = "R8";
        srow = 2'b00; scol = 2'b10; band = 4'd0;
        to_phase(0); to_phase(QT);
        chk("R8 upper setting on b0", int'(offset), 393);
        srow = 2'b00; scol = 2'b00; band = 4'd12;
        to_phase(0); to_phase(QT);
        chk("R8 lower setting on b12", int'(offset), 360);
        srow = 2'b10; scol = 2'b10; band = 4'd15;
        to_phase(0); to_phase(QT);
        chk("R8 b15 as b12", int'(offset), 180);
        // random mix
        tag = "R2 random";
        for (int s = 0; s < 10; s++) begin
            srow = 2'($urandom_range(0, 3));
            scol = 2'($urandom_range(0, 3));
            band = 4'($urandom_range(0, 15));
            run($urandom_range(500, 3000));
            if ($urandom_range(0, 3) == 0) begin
                en = 1'b0;
                run($urandom_range(1, 20));
                en = 1'b1;
            end
        end
        run(P + 10);
        summary();
    end
endmodule